// File: doc/BRIEF.md
# UART interrupt priority identifier

This block merges the four interrupt causes of a UART into one interrupt line and one identification byte that software reads to learn what needs service. The four causes are: a receiver line error, received data (a FIFO fill level at or above a chosen trigger, or a character timeout), an empty transmit holding register, and a change on the modem control inputs. Each cause has its own enable bit. When several causes are active at once, a fixed priority picks the one that is reported.

The block also tracks modem status. It keeps change flags for the clear-to-send, data-set-ready and carrier-detect inputs, and a flag that is set when the ring input ends a ring. It reports the current level of all four lines. The serializer datapaths sit outside the block. Line errors, receive readiness, the RX FIFO count, the timeout and the holding-register empty level all arrive here as conditions.

Top module: `uart_irq_id`

## Requirements
- R1: Bit 0 of `iir_o` is 0 when any enabled cause is pending and 1 otherwise. `irq_o` is high exactly when bit 0 is 0.
- R2: Bits 2:1 of `iir_o` give the highest-priority enabled pending cause: 11 for line error, 10 for received data, 01 for holding empty, 00 for modem status. Each listed cause outranks all those after it. With nothing pending, bits 3:1 are 000.
- R3: `ier_i` bit 0 enables received data, bit 1 enables holding empty, bit 2 enables line error and bit 3 enables modem status. A cause whose bit is 0 has no effect on `iir_o` or `irq_o`.
- R4: With FIFOs off, received data is pending while `rx_ready_i` is high. With FIFOs on, `rx_ready_i` is ignored and received data is pending when `rx_count_i` is at least the trigger selected by `trig_sel_i` (00 selects 1, 01 selects 4, 10 selects 8, 11 selects 14).
- R5: With FIFOs on, `rx_timeout_i` makes received data pending and sets `iir_o` bit 3. The resulting byte is 8'hCC. With FIFOs off, `rx_timeout_i` is ignored.
- R6: `iir_o` bits 7:6 read 11 when `fifo_en_i` is high and 00 when it is low. Bits 5:4 are always 0.
- R7: The holding-empty cause is set one cycle after `thr_empty_i` rises. It is cleared when `thr_empty_i` falls. It is also cleared one cycle after a strobe on `iir_rd_i` that occurs while it is the reported cause. A strobe while another cause is reported leaves it set.
- R8: `msr_o` bits 0, 1 and 3 are set one cycle after a change of `cts_i`, `dsr_i` and `dcd_i` respectively. Bit 2 is set one cycle after `ri_i` falls from 1 to 0; a rise of `ri_i` does not set it.
- R9: A strobe on `msr_rd_i` clears `msr_o` bits 3:0 one cycle later. A line event in the same cycle as the strobe keeps its bit set. Any set bit among 3:0 is the modem status cause.
- R10: `msr_o` bits 4, 5, 6 and 7 show the present levels of `cts_i`, `dsr_i`, `ri_i` and `dcd_i`.
- R11: While in reset and after it, with all inputs low, `iir_o` is 8'h01, `msr_o` is 8'h00 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_i | input | 4 | Cause enables |
| fifo_en_i | input | 1 | FIFO mode on |
| trig_sel_i | input | 2 | RX trigger level select |
| rx_count_i | input | CNT_W (5) | RX FIFO fill count |
| rx_ready_i | input | 1 | Received byte ready (FIFOs off) |
| rx_timeout_i | input | 1 | Character timeout condition |
| line_err_i | input | 1 | Receiver line error condition |
| thr_empty_i | input | 1 | Transmit holding register empty |
| cts_i | input | 1 | Clear-to-send line level |
| dsr_i | input | 1 | Data-set-ready line level |
| ri_i | input | 1 | Ring line level |
| dcd_i | input | 1 | Carrier-detect line level |
| iir_rd_i | input | 1 | Identification byte read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| iir_o | output | 8 | Identification byte |
| msr_o | output | 8 | Modem status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench tests each trigger level one byte below its threshold and exactly at it. A comparator that is off by one, or a wrong level table, would raise received data one byte late or one byte early. It also reads the identification byte while a line error hides a pending holding-empty cause. A design that clears holding-empty on every read would then lose that cause once the line error goes away.

A modem read that lands in the same cycle as a line change must keep the new delta. If the clear wins, the change is lost silently. Finally, the ring line is raised and then lowered. A design that detects the wrong edge would flag the ring too early, or would flag it twice.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [1:0] {
    SRC_MODEM = 2'b00,
    SRC_THRE  = 2'b01,
    SRC_RDA   = 2'b10,
    SRC_LINE  = 2'b11
  } irq_src_e;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_modem.sv
module uart_irq_modem (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  input  logic       msr_rd_i,
  output logic [7:0] msr_o,
  output logic       pend_o
);
  localparam int NLINES = 4;
  localparam int RI_IDX = 2;

  logic [NLINES-1:0] lvl, lvl_q, ev, delta_q;

  assign lvl = {dcd_i, ri_i, dsr_i, cts_i};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    if (i == RI_IDX) begin : g_trail
      assign ev[i] = lvl_q[i] & ~lvl[i];
    end else begin : g_chg
      assign ev[i] = lvl_q[i] ^ lvl[i];
    end

    // event wins over read clear
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)       delta_q[i] <= 1'b0;
      else if (ev[i])    delta_q[i] <= 1'b1;
      else if (msr_rd_i) delta_q[i] <= 1'b0;

    // R8
    delta_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev[i] |=> delta_q[i]);
    // R9
    delta_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msr_rd_i && !ev[i]) |=> !delta_q[i]);
  end

  assign msr_o  = {lvl, delta_q};
  assign pend_o = |delta_q;
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thr_empty_i,
  input  logic iir_rd_i,
  input  logic sel_i,
  output logic pend_o
);
  logic empty_q, pend_q;
  logic rise;

  assign rise = thr_empty_i & ~empty_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      empty_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= thr_empty_i;
      if (!thr_empty_i)          pend_q <= 1'b0;
      else if (rise)             pend_q <= 1'b1;
      else if (iir_rd_i && sel_i) pend_q <= 1'b0;
    end

  assign pend_o = pend_q;

  // R7
  thre_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> pend_q);
  // R7
  thre_rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && sel_i && !rise) |=> !pend_q);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       ier_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_ready_i,
  input  logic             rx_timeout_i,
  input  logic             line_err_i,
  input  logic             thre_pend_i,
  input  logic             modem_pend_i,
  output logic [7:0]       iir_o,
  output logic             irq_o,
  output logic             thre_sel_o
);
  logic rda_lvl, to_act;
  logic en_line, en_rda, en_thre, en_ms;
  irq_src_e src;

  always_comb begin
    rda_lvl = fifo_en_i ? (rx_count_i >= CNT_W'(trig_level(trig_sel_i))) : rx_ready_i;
    to_act  = fifo_en_i & rx_timeout_i;
    en_line = ier_i[2] & line_err_i;
    en_rda  = ier_i[0] & (rda_lvl | to_act);
    en_thre = ier_i[1] & thre_pend_i;
    en_ms   = ier_i[3] & modem_pend_i;

    if (en_line)      src = SRC_LINE;
    else if (en_rda)  src = SRC_RDA;
    else if (en_thre) src = SRC_THRE;
    else              src = SRC_MODEM;

    irq_o      = en_line | en_rda | en_thre | en_ms;
    thre_sel_o = irq_o && (src == SRC_THRE);

    iir_o      = {fifo_en_i, fifo_en_i, 2'b00, 1'b0, 2'b00, 1'b1};
    if (irq_o) begin
      iir_o[0]   = 1'b0;
      iir_o[2:1] = src;
      iir_o[3]   = (src == SRC_RDA) & to_act;
    end
  end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id #(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       ier_i,
  input  logic             fifo_en_i,
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_ready_i,
  input  logic             rx_timeout_i,
  input  logic             line_err_i,
  input  logic             thr_empty_i,
  input  logic             cts_i,
  input  logic             dsr_i,
  input  logic             ri_i,
  input  logic             dcd_i,
  input  logic             iir_rd_i,
  input  logic             msr_rd_i,
  output logic [7:0]       iir_o,
  output logic [7:0]       msr_o,
  output logic             irq_o
);
  logic thre_pend, thre_sel, modem_pend;

  uart_irq_modem u_modem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cts_i    (cts_i),
    .dsr_i    (dsr_i),
    .ri_i     (ri_i),
    .dcd_i    (dcd_i),
    .msr_rd_i (msr_rd_i),
    .msr_o    (msr_o),
    .pend_o   (modem_pend)
  );

  uart_irq_thre u_thre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .thr_empty_i (thr_empty_i),
    .iir_rd_i    (iir_rd_i),
    .sel_i       (thre_sel),
    .pend_o      (thre_pend)
  );

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ier_i        (ier_i),
    .fifo_en_i    (fifo_en_i),
    .trig_sel_i   (trig_sel_i),
    .rx_count_i   (rx_count_i),
    .rx_ready_i   (rx_ready_i),
    .rx_timeout_i (rx_timeout_i),
    .line_err_i   (line_err_i),
    .thre_pend_i  (thre_pend),
    .modem_pend_i (modem_pend),
    .iir_o        (iir_o),
    .irq_o        (irq_o),
    .thre_sel_o   (thre_sel)
  );

  // R1
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !iir_o[0]);
  // R2
  idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (iir_o[3:1] == 3'b000));
  // R6
  fifo_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_o[7] == iir_o[6]) && (iir_o[5:4] == 2'b00));
endmodule

// File: tb/sim_uart_irq_id.sv
module sim_uart_irq_id;
  localparam int CW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] ier = '0;
  logic fifo_en = 0, rx_ready = 0, rx_to = 0, line_err = 0, thr_empty = 0;
  logic [1:0] trig = '0;
  logic [CW-1:0] cnt = '0;
  logic cts = 0, dsr = 0, ri = 0, dcd = 0, iir_rd = 0, msr_rd = 0;
  logic [7:0] iir, msr;
  logic irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  uart_irq_id u0 (
    .clk_i(clk), .rst_ni(rst_n), .ier_i(ier), .fifo_en_i(fifo_en),
    .trig_sel_i(trig), .rx_count_i(cnt), .rx_ready_i(rx_ready),
    .rx_timeout_i(rx_to), .line_err_i(line_err), .thr_empty_i(thr_empty),
    .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .iir_rd_i(iir_rd), .msr_rd_i(msr_rd),
    .iir_o(iir), .msr_o(msr), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic msr_read();
    msr_rd = 1; step(); msr_rd = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R11 iir in reset", iir, 8'h01);
    step(2); rst_n = 1; step();
    chk("R11 iir", iir, 8'h01);
    chk("R11 msr", msr, 8'h00);
    chk("R11 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_enable();
    line_err = 1; rx_ready = 1; ier = 4'b0000; #1;
    chk("R3 all off iir", iir, 8'h01);
    chk("R1 irq low", {7'd0, irq}, 8'h00);
    ier = 4'b0001; #1;
    chk("R3 rda only", iir, 8'h04);
    chk("R1 irq high", {7'd0, irq}, 8'h01);
    ier = 4'b0100; #1;
    chk("R3 line only", iir, 8'h06);
    line_err = 0; rx_ready = 0; ier = 0; step();
  endtask

  task automatic t_fifo();
    int lv[4] = '{1, 4, 8, 14};
    fifo_en = 1; ier = 4'b0001; rx_ready = 1; cnt = 0; #1;
    chk("R4 ready ignored in fifo", iir, 8'hC1);
    rx_ready = 0;
    for (int s = 0; s < 4; s++) begin
      trig = s[1:0];
      cnt = CW'(lv[s] - 1); #1;
      chk("R4 below trigger", iir, 8'hC1);
      cnt = CW'(lv[s]); #1;
      chk("R4 at trigger", iir, 8'hC4);
    end
    cnt = 16; #1;
    chk("R4 full", iir, 8'hC4);
    cnt = 0; rx_to = 1; #1;
    chk("R5 timeout", iir, 8'hCC);
    fifo_en = 0; #1;
    chk("R5 timeout ignored", iir, 8'h01);
    chk("R6 fifo off bits", {6'd0, iir[7:6]}, 8'h00);
    rx_to = 0; ier = 4'b0001; rx_ready = 1; #1;
    chk("R4 non-fifo ready", iir, 8'h04);
    rx_ready = 0; ier = 0; trig = 0; step();
  endtask

  task automatic t_thre();
    ier = 4'b0010; thr_empty = 1; #1;
    chk("R7 not yet set", iir, 8'h01);
    step();
    chk("R7 set after rise", iir, 8'h02);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R7 read clears", iir, 8'h01);
    step(2);
    chk("R7 stays clear", iir, 8'h01);
    thr_empty = 0; step(); thr_empty = 1; step();
    chk("R7 rearmed", iir, 8'h02);
    ier = 4'b0110; line_err = 1; #1;
    chk("R2 line over thre", iir, 8'h06);
    iir_rd = 1; step(); iir_rd = 0; line_err = 0; #1;
    chk("R7 hidden read keeps", iir, 8'h02);
    thr_empty = 0; step();
    chk("R7 cleared on fill", iir, 8'h01);
    ier = 0;
  endtask

  task automatic t_prio();
    ier = 4'hF; line_err = 1; rx_ready = 1; cts = 1; thr_empty = 1; step();
    chk("R2 line top", iir, 8'h06);
    line_err = 0; #1;
    chk("R2 rda next", iir, 8'h04);
    rx_ready = 0; #1;
    chk("R2 thre next", iir, 8'h02);
    iir_rd = 1; step(); iir_rd = 0;
    chk("R2 modem last", iir, 8'h00);
    chk("R1 irq modem", {7'd0, irq}, 8'h01);
    msr_read();
    chk("R9 cleared iir", iir, 8'h01);
    thr_empty = 0; cts = 0; step(); msr_read(); ier = 0;
  endtask

  task automatic t_modem();
    ier = 4'b1000; cts = 1; step();
    chk("R8 cts delta", msr, 8'h11);
    chk("R9 modem pending", iir, 8'h00);
    msr_read();
    chk("R9 read clears", msr, 8'h10);
    msr_rd = 1; dsr = 1; step(); msr_rd = 0;
    chk("R9 event beats read", msr, 8'h32);
    msr_read();
    chk("R10 levels", msr, 8'h30);
    ri = 1; step();
    chk("R8 ri rise no flag", msr, 8'h70);
    ri = 0; step();
    chk("R8 ri fall flag", msr, 8'h34);
    dcd = 1; step();
    chk("R8 dcd delta", msr, 8'hBC);
    msr_read();
    chk("R10 dcd level", msr, 8'hB0);
    cts = 0; dsr = 0; dcd = 0; step(); msr_read();
    chk("R9 final clear", msr, 8'h00);
    ier = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_enable();
        t_fifo();
        t_thre();
        t_prio();
        t_modem();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule